// File: doc/BRIEF.md
# Staggered-Phase Sinc3 Decimator Bank

This block turns the single-bit output of a second-order sigma-delta modulator into a stream of 16-bit codes. It runs on the modulator clock, nominally 20 MHz. One third-order sinc decimator that divides by 256 gives one code about every 12.8 us, or roughly 78 kHz. That is too slow for a fast current loop. This block raises the output rate without shortening the filter window. It runs `NUM_FILT` copies of the same sinc3 decimator side by side and offsets each copy's decimation instant by a fixed slice of the decimation period. The window length, and so the resolution, stays the same. A selector then merges the results into one stream that carries one code every `DEC/NUM_FILT` modulator clocks.

All copies would accumulate the same input in the same way, so the three cumulative-sum stages are built once and shared. Each copy owns only its three-stage difference pipeline, and that pipeline advances only on the copy's own dump cycle. A free-running counter modulo `DEC` sets the dump cycles. Copy k dumps when the counter equals k·DEC/NUM_FILT, so the copies come out in phase order. A copy's code is held back until three dumps have filled its difference pipeline. A one-cycle strobe marks each code that is released.

Top module: `sinc3_stagger_bank`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `code_o` is 0x0000 and `valid_o` is 0.
- R2: No strobe appears until every copy has dumped three times. The first `valid_o` is visible one cycle after the fourth dump of copy 0, which is the 3·DEC+1-th clock edge after reset is released.
- R3: `valid_o` is high for exactly one cycle. Once the bank has settled, consecutive strobes are exactly DEC/NUM_FILT cycles apart.
- R4: `code_o` changes only in a cycle in which `valid_o` is high. Between strobes it holds its value.
- R5: An input bit of 1 contributes +1 and an input bit of 0 contributes 0. A settled bank fed all zeros outputs 0x0000.
- R6: The full-scale result DEC³ (2^24 at DEC=256) saturates to 0xFFFF. Below full scale the code is the top 16 bits of the 3·log2(DEC)-bit result. A settled all-ones input therefore reads 0xFFFF.
- R7: A periodic input whose period divides DEC and whose density of ones is d gives a settled code of d·65536. Densities 1/8, 1/4, 1/2 and 3/4 give 0x2000, 0x4000, 0x8000 and 0xC000.
- R8: Codes leave in phase order, copy 0, then 1, up to NUM_FILT-1, and then repeat. As a result, after a step from all zeros to all ones, the codes never decrease from one strobe to the next, and they reach 0xFFFF.
- R9: The shared sums use 3·log2(DEC)+1 bits with two's-complement wraparound. Results stay exact after the sums have wrapped many times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock; the bitstream is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Modulator bitstream |
| code_o | output | 16 | Reconstructed sample code |
| valid_o | output | 1 | One-cycle strobe marking a new code |

## Verification
The bench sweeps inputs with a known density: all zeros, four periodic densities and all ones. It compares every settled code with d·65536. A wrong saturation shows up as 0x0000 at full scale, and a sign or weighting error shows up as wrong fractions. The long all-ones run lets the shared sums wrap many times, so an accumulator that is too narrow or that saturates gives a wrong code. The bench also checks the cycle of the first strobe and the spacing of every later strobe, which catches an off-by-one in the settle count or in a dump phase. Finally, the bench watches the codes after a step from zeros to ones. If the selector interleaved the copies out of phase order, the codes would fall somewhere in the sequence.

// File: rtl/sinc3_stagger_bank.sv
module sinc3_stagger_bank #(
  parameter int DEC      = 256,
  parameter int NUM_FILT = 4,
  parameter int OUT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_in,
  output logic [OUT_W-1:0] code_o,
  output logic             valid_o
);
  localparam int LG    = $clog2(DEC);
  localparam int ACC_W = 3 * LG + 1;
  localparam int STEP  = DEC / NUM_FILT;

  logic [LG-1:0]    cnt;
  logic [ACC_W-1:0] s1, s2, s3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      s1  <= '0;
      s2  <= '0;
      s3  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      s1  <= s1 + {{(ACC_W-1){1'b0}}, bit_in};
      s2  <= s2 + s1;
      s3  <= s3 + s2;
    end
  end

  logic [ACC_W-1:0]    res [NUM_FILT];
  logic [NUM_FILT-1:0] hit, ready;

  for (genvar k = 0; k < NUM_FILT; k++) begin : g_phase
    logic [ACC_W-1:0] z1, z2, z3, d1, d2;
    logic [1:0]       ndump;

    assign hit[k]   = (cnt == LG'(k * STEP));
    assign d1       = s3 - z1;
    assign d2       = d1 - z2;
    assign res[k]   = d2 - z3;
    assign ready[k] = hit[k] && (ndump == 2'd3);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        z1    <= '0;
        z2    <= '0;
        z3    <= '0;
        ndump <= '0;
      end else if (hit[k]) begin
        z1 <= s3;
        z2 <= d1;
        z3 <= d2;
        if (ndump != 2'd3) ndump <= ndump + 2'd1;
      end
    end
  end

  logic [ACC_W-1:0] sel;
  always_comb begin
    sel = '0;
    for (int k = 0; k < NUM_FILT; k++)
      if (hit[k]) sel = res[k];
  end

  wire [OUT_W-1:0] sat_code = sel[ACC_W-1] ? {OUT_W{1'b1}} : sel[ACC_W-2 -: OUT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= |ready;
      if (|ready) code_o <= sat_code;
    end
  end
endmodule

// File: rtl/sinc3_stagger_bank_chk.sv
module sinc3_stagger_bank_chk #(
  parameter int DEC      = 256,
  parameter int NUM_FILT = 4,
  parameter int OUT_W    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             valid_o,
  input logic [OUT_W-1:0] code_o
);
  localparam int STEP = DEC / NUM_FILT;

  logic [31:0] cyc, gap;
  logic        seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc  <= '0;
      gap  <= '0;
      seen <= 1'b0;
    end else begin
      if (cyc <= 32'(3 * DEC)) cyc <= cyc + 1;
      if (valid_o) begin
        gap  <= 32'd1;
        seen <= 1'b1;
      end else begin
        gap <= gap + 1;
      end
    end
  end

  AST_SETTLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc <= 32'(3 * DEC)) |-> !valid_o); // R2
  AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R3
  AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && seen) |-> (gap == 32'(STEP))); // R3
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(code_o)); // R4
endmodule

bind sinc3_stagger_bank sinc3_stagger_bank_chk #(
  .DEC(DEC), .NUM_FILT(NUM_FILT), .OUT_W(OUT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .valid_o(valid_o), .code_o(code_o)
);

// File: tb/sinc3_stagger_bank_tb_top.sv
module sinc3_stagger_bank_tb_top;
  localparam int DEC  = 256;
  localparam int NF   = 4;
  localparam int STEP = DEC / NF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_in = 1'b0;
  logic [15:0] code_o;
  logic        valid_o;

  always #5 clk = ~clk;

  sinc3_stagger_bank #(.DEC(DEC), .NUM_FILT(NF), .OUT_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .code_o(code_o), .valid_o(valid_o)
  );

  int nchk = 0, nfail = 0;
  int ticks = 0, gap = 0, first_valid = 0, pulses = 0;
  int phase_ctr = 0, ones = 0, per = 1;
  logic        seen = 1'b0, expect_en = 1'b0, mono = 1'b0;
  logic [15:0] exp_code = '0, last_code = '0, prev_mono = '0;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    ticks++;
    gap++;
    if (valid_o) begin
      pulses++;
      if (!seen) begin
        first_valid = ticks;
        chk(ticks == 3 * DEC + 1, "R2 first strobe edge", ticks, 3 * DEC + 1);
      end else begin
        chk(gap == STEP, "R3 strobe spacing", gap, STEP);
      end
      seen = 1'b1;
      gap = 0;
      if (expect_en) chk(code_o == exp_code, "R5/R6/R7/R9 settled code", code_o, exp_code);
      if (mono) begin
        chk(code_o >= prev_mono, "R8 phase order monotone step", code_o, prev_mono);
        prev_mono = code_o;
      end
    end else begin
      chk(code_o == last_code, "R4 code held between strobes", code_o, last_code);
    end
    last_code = code_o;
    bit_in = ((phase_ctr % per) < ones);
    phase_ctr++;
  endtask

  task automatic pattern(input int n1, input int p, input logic [15:0] e);
    ones = n1;
    per = p;
    expect_en = 1'b0;
    for (int i = 0; i < 4 * DEC; i++) tick();
    exp_code = e;
    expect_en = 1'b1;
    for (int i = 0; i < 2 * DEC; i++) tick();
    expect_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(code_o == 16'h0000, "R1 code in reset", code_o, 0);
    chk(valid_o == 1'b0, "R1 strobe in reset", valid_o, 0);
    rst_n = 1'b1;
    tick();
    chk(code_o == 16'h0000 && !valid_o, "R1 first cycle after reset", code_o, 0);
    for (int i = 1; i < 3 * DEC; i++) tick();
    chk(pulses == 0, "R2 quiet while settling", pulses, 0);
    pattern(0, 1, 16'h0000);
    pattern(1, 4, 16'h4000);
    pattern(2, 4, 16'h8000);
    pattern(3, 4, 16'hC000);
    pattern(1, 8, 16'h2000);
    pattern(1, 1, 16'hFFFF);
    for (int i = 0; i < 8; i++) pattern(1, 1, 16'hFFFF);
    pattern(0, 1, 16'h0000);
    ones = 1;
    per = 1;
    mono = 1'b1;
    prev_mono = '0;
    for (int i = 0; i < 5 * DEC; i++) tick();
    mono = 1'b0;
    chk(prev_mono == 16'hFFFF, "R8 step reaches full scale", prev_mono, 16'hFFFF);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=<150000", wd);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule